// File: doc/BRIEF.md
# Slot-Qualified Command Match Trigger

This block is a debug trigger that watches the frames a link receiver has already decoded. Each received frame carries three 40-bit command slots, called A, B and C. Three programmable pattern pairs are checked in parallel against every slot. Each pair has a match value and a mask. Each pair drives one event bit. A pair fires when its pattern appears in any of the three slots.

Slots B and C may hold either commands or data payload. By default, a hit in those slots counts only when the slot really holds a command. That is judged from the frame-type flag, the decoded slot A command and the decoded slot B command of the same frame. Setting the top bit of a pair's mask turns this qualification off, so the pair also matches raw data.

A full-frame compare (pair 0 on slot A, pair 1 on slot B and pair 2 on slot C, all at once) is offered as an extra source. Each event bit is chosen from thirteen sources by a per-pair selector. Slot A and full-frame matching stay silent until the receiver reports that its inputs are aligned. Software programs the patterns and selectors through a small address/data/write-enable port.

Top module: `slot_match_trigger`

## Requirements
- R1: `rst` is synchronous and active high. While it is asserted and in the cycle after, `eventOut` is 0. All match values, masks and selectors are cleared to 0, so selector 0 (any slot) is in use.
- R2: For bits 38:0, a slot matches a pair when every bit whose mask bit is 0 equals the match bit. Mask bits set to 1 are don't-care. Slot bit 39 never takes part in the compare.
- R3: The three pairs work independently. With selector 0, a pair's event fires when its pattern matches slot A, slot B or slot C (an OR across the slots).
- R4: A frame presented with `frameValid` high at clock edge t sets the per-slot hit registers at edge t. It affects `eventOut` at edge t+1, so the event lags the frame by two clock edges.
- R5: When a pair's mask bit 39 is 1, slots B and C are compared whatever the frame type and the decoded commands.
- R6: When a pair's mask bit 39 is 0, a slot B hit is dropped if `isCmdFrame` is 0, or if `cmdA` is Sync (code 1) or Soft Reset (code 2). Other `cmdA` codes do not block the hit.
- R7: When a pair's mask bit 39 is 0, a slot C hit is dropped under the same conditions as in R6. It is also dropped when `cmdB` is Write Configuration Register (code 3).
- R8: Match bit 39 has no effect. Mask bit 39 = 0 with match bit 39 = 1 behaves exactly like command-only mode.
- R9: While `alignDone` is 0, slot A hits and full-frame hits are not produced. Slots B and C are not gated by `alignDone`.
- R10: The full-frame source is high when, in one frame, pair 0 matches slot A, pair 1 matches slot B and pair 2 matches slot C. This compare ignores the command qualification.
- R11: Each pair has a 4-bit selector. The codes are:
  - 0: any-slot OR
  - 1: slot A
  - 2: slot B
  - 3: slot C
  - 4: full frame
  - 5 to 12: `extEvt[0]` to `extEvt[7]`, registered in step with the slot hits
  - 13 to 15: constant 0
- R12: Register writes use these addresses:
  - 0 to 2: match value of pairs 0 to 2
  - 3 to 5: mask of pairs 0 to 2
  - 6: the selectors, with pair p's selector in data bits 4p+3:4p

  A write takes effect from the next edge. Writes to address 7 change nothing. With `frameValid` low, no slot or full-frame hit is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Register write enable |
| cfgAddr | input | 3 | Register address |
| cfgData | input | 40 | Register write data |
| frameValid | input | 1 | A decoded frame is present this cycle |
| slotA | input | 40 | Slot A contents |
| slotB | input | 40 | Slot B contents |
| slotC | input | 40 | Slot C contents |
| isCmdFrame | input | 1 | Frame type is command |
| cmdA | input | 3 | Decoded slot A command code |
| cmdB | input | 3 | Decoded slot B command code |
| alignDone | input | 1 | Receiver input alignment finished |
| extEvt | input | 8 | Extra event sources for the selectors |
| eventOut | output | 3 | Registered event bit per pair |

## Verification
The bench targets the frames where qualification flips a result:
- A data frame with a pattern in slot B. A design that ignores frame type would fire here.
- Sync and Soft Reset in slot A. A design that checks only the frame type would pass slot B and C hits through.
- A Write Configuration Register in slot B. This must silence slot C while slot B still fires. A design that applies the rule to the wrong slot loses the slot B event.

It also drives frames before alignment, where a slot A hit leaking through would raise an event. It sets match bit 39 alone, which must not switch off qualification. It uses selector codes 13 to 15, where a design that indexes past the source list would show garbage. A long mixed run then compares every cycle against a behavioural model, which catches one-cycle latency slips.

// File: rtl/slot_trig_pkg.sv
package slot_trig_pkg;

  localparam int PAIRS = 3;
  localparam int CMD_W = 3;

  // decoded command codes the qualifier cares about
  localparam logic [CMD_W-1:0] CMD_SYNC       = 3'd1;
  localparam logic [CMD_W-1:0] CMD_SOFT_RESET = 3'd2;
  localparam logic [CMD_W-1:0] CMD_CFG_WRITE  = 3'd3;

  // selector source codes
  localparam int SRC_ANY   = 0;
  localparam int SRC_A     = 1;
  localparam int SRC_B     = 2;
  localparam int SRC_C     = 3;
  localparam int SRC_FULL  = 4;
  localparam int SRC_EXT0  = 5;

  // per-cycle compare enables from control to datapath
  typedef struct packed {
    logic [PAIRS-1:0] enA;
    logic [PAIRS-1:0] enB;
    logic [PAIRS-1:0] enC;
    logic             enFull;
  } strobe_t;

endpackage

// File: rtl/slot_trig_ctrl.sv
module slot_trig_ctrl
  import slot_trig_pkg::*;
#(
  parameter int SLOT_W = 40,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [SLOT_W-1:0]             regWdata,
  input  logic                          frameValid,
  input  logic                          isCmdFrame,
  input  logic [CMD_W-1:0]              cmdA,
  input  logic [CMD_W-1:0]              cmdB,
  input  logic                          alignDone,
  output strobe_t                       strobe,
  output logic [PAIRS-1:0][SLOT_W-1:0]  matchReg,
  output logic [PAIRS-1:0][SLOT_W-1:0]  maskReg,
  output logic [PAIRS-1:0][SEL_W-1:0]   selReg
);

  localparam int QUAL_BIT  = SLOT_W - 1;
  localparam int MASK_BASE = PAIRS;
  localparam int SEL_ADDR  = 2 * PAIRS;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      matchReg <= '0;
      maskReg  <= '0;
      selReg   <= '0;
    end else if (regWe) begin
      for (int p = 0; p < PAIRS; p++) begin
        if (regAddr == ADDR_W'(p))             matchReg[p] <= regWdata;
        if (regAddr == ADDR_W'(MASK_BASE + p)) maskReg[p]  <= regWdata;
      end
      if (regAddr == ADDR_W'(SEL_ADDR))
        selReg <= regWdata[PAIRS*SEL_W-1:0];
    end
  end

  // command qualification for slots B and C
  logic aBlocks;
  logic bIsCmd;
  logic cIsCmd;

  always_comb begin
    aBlocks = (cmdA == CMD_SYNC) || (cmdA == CMD_SOFT_RESET);
    bIsCmd  = isCmdFrame && !aBlocks;
    cIsCmd  = bIsCmd && (cmdB != CMD_CFG_WRITE);
  end

  always_comb begin
    strobe.enFull = frameValid && alignDone;
    for (int p = 0; p < PAIRS; p++) begin
      strobe.enA[p] = frameValid && alignDone;
      strobe.enB[p] = frameValid && (maskReg[p][QUAL_BIT] || bIsCmd);
      strobe.enC[p] = frameValid && (maskReg[p][QUAL_BIT] || cIsCmd);
    end
  end

  // R12: a write to match slot 0 lands on the next edge
  a_r12_match_write_lands: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == ADDR_W'(0)) |=> (matchReg[0] == $past(regWdata)));

  // R12: an address above the selector register changes nothing
  a_r12_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr > ADDR_W'(SEL_ADDR)) |=>
      ($stable(matchReg) && $stable(maskReg) && $stable(selReg)));

endmodule

// File: rtl/slot_trig_dp.sv
module slot_trig_dp
  import slot_trig_pkg::*;
#(
  parameter int SLOT_W = 40,
  parameter int SEL_W  = 4,
  parameter int EXT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       strobe,
  input  logic [SLOT_W-1:0]             slotA,
  input  logic [SLOT_W-1:0]             slotB,
  input  logic [SLOT_W-1:0]             slotC,
  input  logic [PAIRS-1:0][SLOT_W-1:0]  matchReg,
  input  logic [PAIRS-1:0][SLOT_W-1:0]  maskReg,
  input  logic [PAIRS-1:0][SEL_W-1:0]   selReg,
  input  logic [EXT_W-1:0]              extEvt,
  output logic [PAIRS-1:0]              eventOut
);

  localparam int NUM_SRC  = SRC_EXT0 + EXT_W;
  localparam int SRC_SPAN = 1 << SEL_W;
  localparam logic [SLOT_W-1:0] CMP_SKIP = {1'b1, {(SLOT_W-1){1'b0}}};

  function automatic logic patHit(input logic [SLOT_W-1:0] data,
                                  input logic [SLOT_W-1:0] pat,
                                  input logic [SLOT_W-1:0] dontCare);
    return &((data ~^ pat) | dontCare | CMP_SKIP);
  endfunction

  logic [PAIRS-1:0] rawA, rawB, rawC;
  logic             fullRaw;

  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      rawA[p] = patHit(slotA, matchReg[p], maskReg[p]);
      rawB[p] = patHit(slotB, matchReg[p], maskReg[p]);
      rawC[p] = patHit(slotC, matchReg[p], maskReg[p]);
    end
    fullRaw = rawA[0] && rawB[1] && rawC[2];
  end

  // stage 1: registered per-slot hits
  logic [PAIRS-1:0] hitA, hitB, hitC;
  logic             fullHit;
  logic [EXT_W-1:0] extReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      hitA    <= '0;
      hitB    <= '0;
      hitC    <= '0;
      fullHit <= 1'b0;
      extReg  <= '0;
    end else begin
      hitA    <= rawA & strobe.enA;
      hitB    <= rawB & strobe.enB;
      hitC    <= rawC & strobe.enC;
      fullHit <= fullRaw && strobe.enFull;
      extReg  <= extEvt;
    end
  end

  // stage 2: source select and event register
  logic [PAIRS-1:0][NUM_SRC-1:0]  srcVec;
  logic [PAIRS-1:0][SRC_SPAN-1:0] srcPad;
  logic [PAIRS-1:0]               evtNext;

  for (genvar p = 0; p < PAIRS; p++) begin : g_sel
    assign srcVec[p] = {extReg, fullHit, hitC[p], hitB[p], hitA[p],
                        hitA[p] | hitB[p] | hitC[p]};
    assign srcPad[p] = SRC_SPAN'(srcVec[p]);
    assign evtNext[p] = srcPad[p][selReg[p]];
  end

  always_ff @(posedge clk) begin
    if (rst) eventOut <= '0;
    else     eventOut <= evtNext;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_chk
    // R6: no slot B hit when control withholds the slot B enable
    a_r6_b_gated: assert property (@(posedge clk) disable iff (rst)
      !strobe.enB[p] |=> !hitB[p]);
    // R7: no slot C hit when control withholds the slot C enable
    a_r7_c_gated: assert property (@(posedge clk) disable iff (rst)
      !strobe.enC[p] |=> !hitC[p]);
    // R9: slot A stays silent without its enable
    a_r9_a_gated: assert property (@(posedge clk) disable iff (rst)
      !strobe.enA[p] |=> !hitA[p]);
    // R3: any registered slot hit with selector 0 raises the event
    a_r3_any_slot_fires: assert property (@(posedge clk) disable iff (rst)
      ((hitA[p] || hitB[p] || hitC[p]) && selReg[p] == '0) |=> eventOut[p]);
    // R11: out-of-range selector codes give a quiet event
    a_r11_high_sel_quiet: assert property (@(posedge clk) disable iff (rst)
      (int'(selReg[p]) >= NUM_SRC) |=> !eventOut[p]);
  end

  // R9: full-frame source silent without its enable
  a_r9_full_gated: assert property (@(posedge clk) disable iff (rst)
    !strobe.enFull |=> !fullHit);

endmodule

// File: rtl/slot_match_trigger.sv
module slot_match_trigger
  import slot_trig_pkg::*;
#(
  parameter int SLOT_W = 40,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 3,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [SLOT_W-1:0] cfgData,
  input  logic              frameValid,
  input  logic [SLOT_W-1:0] slotA,
  input  logic [SLOT_W-1:0] slotB,
  input  logic [SLOT_W-1:0] slotC,
  input  logic              isCmdFrame,
  input  logic [CMD_W-1:0]  cmdA,
  input  logic [CMD_W-1:0]  cmdB,
  input  logic              alignDone,
  input  logic [EXT_W-1:0]  extEvt,
  output logic [PAIRS-1:0]  eventOut
);

  strobe_t                      strobe;
  logic [PAIRS-1:0][SLOT_W-1:0] matchReg;
  logic [PAIRS-1:0][SLOT_W-1:0] maskReg;
  logic [PAIRS-1:0][SEL_W-1:0]  selReg;

  slot_trig_ctrl #(.SLOT_W(SLOT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .regWe      (cfgWe),
    .regAddr    (cfgAddr),
    .regWdata   (cfgData),
    .frameValid (frameValid),
    .isCmdFrame (isCmdFrame),
    .cmdA       (cmdA),
    .cmdB       (cmdB),
    .alignDone  (alignDone),
    .strobe     (strobe),
    .matchReg   (matchReg),
    .maskReg    (maskReg),
    .selReg     (selReg)
  );

  slot_trig_dp #(.SLOT_W(SLOT_W), .SEL_W(SEL_W), .EXT_W(EXT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .slotA    (slotA),
    .slotB    (slotB),
    .slotC    (slotC),
    .matchReg (matchReg),
    .maskReg  (maskReg),
    .selReg   (selReg),
    .extEvt   (extEvt),
    .eventOut (eventOut)
  );

  // R1: the cycle after reset is released the event outputs are still quiet
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (eventOut == '0));

endmodule

// File: tb/slot_match_trigger_test.sv
`timescale 1ns/1ps
module slot_match_trigger_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [39:0] cfgData = '0;
  logic        frameValid = 1'b0;
  logic [39:0] slotA = '0, slotB = '0, slotC = '0;
  logic        isCmdFrame = 1'b0;
  logic [2:0]  cmdA = '0, cmdB = '0;
  logic        alignDone = 1'b0;
  logic [7:0]  extEvt = '0;
  logic [2:0]  eventOut;

  always #4 clk = ~clk;

  slot_match_trigger uut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .frameValid(frameValid), .slotA(slotA), .slotB(slotB), .slotC(slotC),
    .isCmdFrame(isCmdFrame), .cmdA(cmdA), .cmdB(cmdB), .alignDone(alignDone),
    .extEvt(extEvt), .eventOut(eventOut)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";
  bit    finished = 0;

  // behavioural reference model
  bit [39:0] mMatch [3];
  bit [39:0] mMask  [3];
  int        mSel   [3];
  bit        s1A [3], s1B [3], s1C [3];
  bit        s1Full;
  bit [7:0]  s1Ext;
  bit [2:0]  expEvent;

  function automatic bit refHit(bit [39:0] d, bit [39:0] m, bit [39:0] k);
    for (int i = 0; i < 39; i++)
      if (!k[i] && d[i] != m[i]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 3; p++) begin
        mMatch[p] = '0; mMask[p] = '0; mSel[p] = 0;
        s1A[p] = 0; s1B[p] = 0; s1C[p] = 0;
      end
      s1Full = 0; s1Ext = '0; expEvent = '0;
    end else begin
      bit [2:0] nextEvt;
      bit bCmd, cCmd;
      for (int p = 0; p < 3; p++) begin
        case (mSel[p])
          0: nextEvt[p] = s1A[p] | s1B[p] | s1C[p];
          1: nextEvt[p] = s1A[p];
          2: nextEvt[p] = s1B[p];
          3: nextEvt[p] = s1C[p];
          4: nextEvt[p] = s1Full;
          5, 6, 7, 8, 9, 10, 11, 12: nextEvt[p] = s1Ext[mSel[p]-5];
          default: nextEvt[p] = 0;
        endcase
      end
      expEvent = nextEvt;
      bCmd = isCmdFrame && cmdA != 3'd1 && cmdA != 3'd2;
      cCmd = bCmd && cmdB != 3'd3;
      for (int p = 0; p < 3; p++) begin
        s1A[p] = frameValid && alignDone && refHit(slotA, mMatch[p], mMask[p]);
        s1B[p] = frameValid && (mMask[p][39] || bCmd) && refHit(slotB, mMatch[p], mMask[p]);
        s1C[p] = frameValid && (mMask[p][39] || cCmd) && refHit(slotC, mMatch[p], mMask[p]);
      end
      s1Full = frameValid && alignDone && refHit(slotA, mMatch[0], mMask[0]) &&
               refHit(slotB, mMatch[1], mMask[1]) && refHit(slotC, mMatch[2], mMask[2]);
      s1Ext = extEvt;
      if (cfgWe) begin
        if (cfgAddr <= 3'd2)      mMatch[cfgAddr] = cfgData;
        else if (cfgAddr <= 3'd5) mMask[cfgAddr-3] = cfgData;
        else if (cfgAddr == 3'd6)
          for (int p = 0; p < 3; p++) mSel[p] = int'(cfgData[4*p +: 4]);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (eventOut !== expEvent) begin
        miscompares++;
        $display("FAIL %s: eventOut=%b expected=%b at %0t", curReq, eventOut, expEvent, $time);
      end
    end
  end

  task automatic idle(input int n);
    frameValid = 0; cfgWe = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] a, input logic [39:0] d);
    frameValid = 0; cfgWe = 1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic frame(input logic [39:0] a, input logic [39:0] b, input logic [39:0] c,
                       input logic cf, input logic [2:0] ca, input logic [2:0] cb);
    cfgWe = 0; frameValid = 1; slotA = a; slotB = b; slotC = c;
    isCmdFrame = cf; cmdA = ca; cmdB = cb;
    @(negedge clk);
  endtask

  // expects a directed outcome two edges after the frame
  task automatic expectEvt(input string req, input logic [2:0] want);
    vectors++;
    if (eventOut !== want) begin
      miscompares++;
      $display("FAIL %s: eventOut=%b expected=%b", req, eventOut, want);
    end
  endtask

  localparam logic [39:0] P0 = 40'h00_1234_5678;
  localparam logic [39:0] P1 = 40'h00_0BAD_F00D;
  localparam logic [39:0] P2 = 40'h00_7777_0001;
  localparam logic [39:0] FL = 40'h55_5555_5555;

  task automatic runFrame(input string req, input logic [39:0] a, input logic [39:0] b,
                          input logic [39:0] c, input logic cf, input logic [2:0] ca,
                          input logic [2:0] cb, input logic [2:0] want);
    curReq = req;
    frame(a, b, c, cf, ca, cb);
    frameValid = 0;
    @(negedge clk);
    expectEvt(req, want);
  endtask

  initial begin
    // R1: reset
    curReq = "R1";
    repeat (3) @(negedge clk);
    expectEvt("R1", 3'b000);
    rst = 0;
    @(negedge clk);
    expectEvt("R1", 3'b000);
    alignDone = 1;
    // R1: cleared registers match an all-zero slot A with selector 0
    runFrame("R1", 40'h0, FL, FL, 1, 0, 0, 3'b111);
    idle(2);

    cfg(0, P0); cfg(1, P1); cfg(2, P2);
    cfg(3, 40'h00_0000_00FF); cfg(4, 40'h0); cfg(5, 40'h0); cfg(6, 40'h0);
    idle(2);

    // R2: don't-care low byte and a miss on a cared bit
    runFrame("R2", P0 ^ 40'h00_0000_00A5, FL, FL, 1, 0, 0, 3'b001);
    runFrame("R2", P0 ^ 40'h00_0000_0100, FL, FL, 1, 0, 0, 3'b000);
    runFrame("R2", P0 ^ 40'h80_0000_0000, FL, FL, 1, 0, 0, 3'b001);
    // R3: independent pairs, each found in a different slot
    runFrame("R3", P2, P0, P1, 1, 0, 0, 3'b111);
    runFrame("R3", FL, FL, P1, 1, 0, 0, 3'b010);
    // R4: latency, frame followed by a quiet cycle
    curReq = "R4";
    frame(FL, P2, FL, 1, 0, 0);
    frameValid = 0;
    expectEvt("R4", 3'b000);
    @(negedge clk);
    expectEvt("R4", 3'b100);
    @(negedge clk);
    expectEvt("R4", 3'b000);
    // R6: command-only slot B qualification
    runFrame("R6", FL, P1, FL, 0, 0, 0, 3'b000);
    runFrame("R6", FL, P1, FL, 1, 1, 0, 3'b000);
    runFrame("R6", FL, P1, FL, 1, 2, 0, 3'b000);
    runFrame("R6", FL, P1, FL, 1, 5, 0, 3'b010);
    // R7: slot C extra block on configuration write in slot B
    runFrame("R7", FL, FL, P2, 1, 0, 3, 3'b000);
    runFrame("R7", FL, P1, P2, 1, 0, 3, 3'b010);
    runFrame("R7", FL, FL, P2, 1, 1, 0, 3'b000);
    runFrame("R7", FL, FL, P2, 1, 0, 4, 3'b100);
    // R8: match bit 39 alone keeps command-only mode
    cfg(1, P1 | 40'h80_0000_0000);
    runFrame("R8", FL, P1, FL, 0, 0, 0, 3'b000);
    runFrame("R8", FL, P1, FL, 1, 0, 0, 3'b010);
    // R5: mask bit 39 opens slots B and C to data
    cfg(4, 40'h80_0000_0000);
    runFrame("R5", FL, P1, FL, 0, 1, 3, 3'b010);
    runFrame("R5", FL, FL, P1, 0, 2, 3, 3'b010);
    // R9: no slot A or full-frame before alignment
    alignDone = 0;
    runFrame("R9", P0, FL, FL, 1, 0, 0, 3'b000);
    runFrame("R9", FL, P1, FL, 1, 0, 0, 3'b010);
    cfg(6, 40'h444);
    runFrame("R9", P0, P1, P2, 1, 0, 0, 3'b000);
    alignDone = 1;
    // R10: full frame, unqualified
    runFrame("R10", P0, P1, P2, 0, 1, 3, 3'b111);
    runFrame("R10", P0, P1, FL, 1, 0, 0, 3'b000);
    // R11: selector codes
    cfg(6, 40'h321);
    runFrame("R11", P0, P1, P2, 1, 0, 0, 3'b111);
    runFrame("R11", P0, FL, FL, 1, 0, 0, 3'b001);
    curReq = "R11";
    cfg(6, 40'hC85);
    extEvt = 8'h81; frame(FL, FL, FL, 1, 0, 0); extEvt = 0; frameValid = 0;
    @(negedge clk);
    expectEvt("R11", 3'b101);
    cfg(6, 40'hFED);
    extEvt = 8'hFF;
    runFrame("R11", 40'h0, 40'h0, 40'h0, 1, 0, 0, 3'b000);
    extEvt = 0;
    // R12: unmapped address and idle frames
    cfg(6, 40'h000);
    cfg(7, 40'hFF_FFFF_FFFF);
    runFrame("R12", P0, FL, FL, 1, 0, 0, 3'b001);
    curReq = "R12";
    slotA = P0; slotB = P1; slotC = P2; frameValid = 0;
    repeat (2) @(negedge clk);
    expectEvt("R12", 3'b000);

    // R3: mixed run against the model
    curReq = "R3";
    for (int i = 0; i < 600; i++) begin
      logic [39:0] pool [4];
      pool[0] = P0; pool[1] = P1; pool[2] = P2; pool[3] = 40'($urandom) ^ 40'h5A_0000_0000;
      if ($urandom_range(0, 15) == 0) begin
        int r = $urandom_range(0, 3);
        if (r == 0) cfg(3'($urandom_range(3, 5)), {1'($urandom_range(0, 1)), 31'h0, 8'($urandom)});
        else if (r == 1) cfg(6, 40'($urandom_range(0, 4095)));
        else if (r == 2) cfg(3'($urandom_range(0, 2)), pool[$urandom_range(0, 2)]);
        else cfg(7, 40'($urandom));
      end else begin
        alignDone = ($urandom_range(0, 7) != 0);
        extEvt = 8'($urandom);
        frameValid = ($urandom_range(0, 5) != 0);
        cfgWe = 0;
        slotA = pool[$urandom_range(0, 3)];
        slotB = pool[$urandom_range(0, 3)];
        slotC = pool[$urandom_range(0, 3)];
        isCmdFrame = 1'($urandom_range(0, 1));
        cmdA = 3'($urandom_range(0, 4));
        cmdB = 3'($urandom_range(0, 4));
        @(negedge clk);
      end
    end
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule